// File: doc/BRIEF.md
# Experiment Signal Projection Wrapper

This block places the input and output ports of an experiment circuit behind a small memory-style port. A host-side controller sees only an address, a write strobe, write data and registered read data. It handles every experiment signal by reading and writing numbered slots, and it never touches the experiment's own pins. Signals that feed the experiment are held in registers inside the wrapper. The controller can write them and read them back. Signals that the experiment produces are sampled and can only be read.

The layout is fixed at elaboration from a table of signal widths and directions. Each signal takes as many bus-wide slots as its width needs, and signals are placed one after another in table order. A wide signal is split most significant part first, and any bits left over in a slot read as zero. The experiment's clock and reset do not appear in the slot space. The wrapper forwards them on dedicated pins, so the controller can step the experiment at whatever pace it likes. The default configuration has an 8-bit bus and a 3-bit address. It carries a run-enable bit, a load bit, a 12-bit preload value and a 12-bit counter result.

Top module: `proj_wrapper`

## Requirements
- R1: While `rst` is high at a `sys_clk` rising edge, every input-signal register and `dout` become zero, so `drive_bus` reads all zeros after that edge.
- R2: Slots are given out in table order, starting at address 0, and each signal receives ceil(width/DATA_W) consecutive addresses of its own. With the defaults this gives: address 0 is run-enable (input, bit 0 of the buses); address 1 is load (input, bit 1); addresses 2 and 3 are the 12-bit preload (input, bits 13:2); addresses 4 and 5 are the counter value (output, bits 25:14); addresses 6 and 7 are unmapped.
- R3: A multi-slot signal is split big-endian: its lowest address carries its most significant bits. The unused upper bits of the partly filled top slot, and of any signal narrower than the bus, read as zero.
- R4: A write with `we` high to an input-signal slot replaces only that slot's bits at the `sys_clk` edge, and the new value appears on `drive_bus` after that edge. Bits of `din` that fall outside the signal's width are discarded. The signal's other slots keep their values.
- R5: `dout` is registered: after a `sys_clk` edge it holds the contents of the address presented before that edge, so an address change shows up one edge later.
- R6: A write and a read of the same slot in the same cycle return the slot's value from before the write (read-first).
- R7: A write to an output-signal slot or to an unmapped address changes no input register; `drive_bus` stays unchanged.
- R8: A read of an unmapped address returns zero.
- R9: An output-signal slot returns the value on the matching bits of `sense_bus` at the edge that samples the read.
- R10: `xp_clk` follows `exp_clk` and `xp_rst` follows `rst`, without any register in the path.
- R11: An input-signal slot reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Clock for the slot interface and the input registers |
| exp_clk | input | 1 | Experiment clock supplied by the controller |
| rst | input | 1 | Synchronous active-high reset, also forwarded to the experiment |
| addr | input | ADDR_W | Slot address |
| we | input | 1 | Write strobe |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| drive_bus | output | TOTAL_W | Packed input-signal values fed to the experiment; output-signal positions are zero |
| sense_bus | input | TOTAL_W | Packed values from the experiment; only output-signal positions are used |
| xp_clk | output | 1 | Experiment clock |
| xp_rst | output | 1 | Experiment reset |

## Verification
The assertions check four things on every cycle: at most one signal claims any address, a write lands its low slot in the register, writes to read-only or unmapped slots leave `drive_bus` alone, and an unmapped read yields zero one edge later. The bench walks through the whole address range of the default map. It puts many preload values through both slots of the 12-bit input and runs a counter experiment from bench-chosen starting points, including one that wraps. Only these scenarios can show the big-endian split with its zero padding, the read-first collision, the one-edge read latency and a reset during operation.

// File: rtl/proj_pkg.sv
package proj_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_RO   = 2'd1,
      SLOT_RW   = 2'd2
   } slot_kind_e;

   // number of bus-wide slots a signal of the given width occupies
   function automatic int slots_for(input int width, input int dw);
      return (width + dw - 1) / dw;
   endfunction

endpackage

// File: rtl/proj_addr_decode.sv
module proj_addr_decode
   import proj_pkg::*;
#(
   parameter int          ADDR_W          = 3,
   parameter int          DATA_W          = 8,
   parameter int          N_SIG           = 4,
   parameter int unsigned SIG_W [N_SIG]   = '{1, 1, 12, 12},
   parameter bit [N_SIG-1:0] SIG_IS_IN    = 4'b0111
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   output logic [N_SIG-1:0]  hit,
   output logic [ADDR_W-1:0] frag,
   output slot_kind_e        kind
);

   function automatic int base_of(input int idx);
      int acc;
      acc = 0;
      for (int j = 0; j < idx; j++) acc += slots_for(int'(SIG_W[j]), DATA_W);
      return acc;
   endfunction

   logic [31:0]       a32;
   logic [ADDR_W-1:0] offs_arr [N_SIG];

   assign a32 = 32'(addr);

   for (genvar i = 0; i < N_SIG; i++) begin : g_sig
      localparam int BASE = base_of(i);
      localparam int NF   = slots_for(int'(SIG_W[i]), DATA_W);
      logic [31:0] diff;
      // wraps to a large value below BASE, so one compare covers both bounds
      assign diff        = a32 - 32'(BASE);
      assign hit[i]      = diff < 32'(NF);
      assign offs_arr[i] = diff[ADDR_W-1:0];
   end

   always_comb begin
      frag = '0;
      kind = SLOT_FREE;
      for (int i = 0; i < N_SIG; i++) begin
         if (hit[i]) begin
            frag = frag | offs_arr[i];
            kind = SIG_IS_IN[i] ? SLOT_RW : SLOT_RO;
         end
      end
   end

   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit)); // R2

endmodule

// File: rtl/proj_in_reg.sv
module proj_in_reg
   import proj_pkg::*;
#(
   parameter int W      = 12,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] frag,
   input  logic [DATA_W-1:0] wdata,
   output logic [W-1:0]      val
);

   localparam int NF = slots_for(W, DATA_W);
   localparam int PW = NF * DATA_W;
   localparam int LW = (W < DATA_W) ? W : DATA_W;

   logic [W-1:0]  val_q;
   logic [PW-1:0] pad_nxt;
   int            sel;

   always_comb begin
      pad_nxt = PW'(val_q);
      sel     = (NF - 1 - int'(frag)) * DATA_W;
      if (int'(frag) < NF) pad_nxt[sel +: DATA_W] = wdata;
   end

   if (PW > W) begin : g_pad
      logic unused_pad_bits;
      assign unused_pad_bits = ^pad_nxt[PW-1:W];
   end

   always_ff @(posedge clk) begin
      if (rst)        val_q <= '0;
      else if (wr_en) val_q <= pad_nxt[W-1:0];
   end

   assign val = val_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(val_q)); // R7

   AST_LOW_SLOT_LANDS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && frag == ADDR_W'(NF - 1)) |=> val_q[LW-1:0] == $past(wdata[LW-1:0])); // R4

endmodule

// File: rtl/proj_frag_sel.sv
module proj_frag_sel
   import proj_pkg::*;
#(
   parameter int W      = 12,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 3
) (
   input  logic [W-1:0]      val,
   input  logic [ADDR_W-1:0] frag,
   output logic [DATA_W-1:0] q
);

   localparam int NF = slots_for(W, DATA_W);
   localparam int PW = NF * DATA_W;

   logic [PW-1:0] pad;
   int            sel;

   always_comb begin
      pad = PW'(val);
      sel = (NF - 1 - int'(frag)) * DATA_W;
      q   = '0;
      if (int'(frag) < NF) q = pad[sel +: DATA_W];
   end

endmodule

// File: rtl/proj_wrapper.sv
module proj_wrapper
   import proj_pkg::*;
#(
   parameter int          ADDR_W          = 3,
   parameter int          DATA_W          = 8,
   parameter int          N_SIG           = 4,
   parameter int unsigned SIG_W [N_SIG]   = '{1, 1, 12, 12},
   parameter bit [N_SIG-1:0] SIG_IS_IN    = 4'b0111,
   parameter int          TOTAL_W         = 26
) (
   input  logic               sys_clk,
   input  logic               exp_clk,
   input  logic               rst,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               we,
   input  logic [DATA_W-1:0]  din,
   output logic [DATA_W-1:0]  dout,
   output logic [TOTAL_W-1:0] drive_bus,
   input  logic [TOTAL_W-1:0] sense_bus,
   output logic               xp_clk,
   output logic               xp_rst
);

   function automatic int bits_before(input int idx);
      int acc;
      acc = 0;
      for (int j = 0; j < idx; j++) acc += int'(SIG_W[j]);
      return acc;
   endfunction

   function automatic int slots_before(input int idx);
      int acc;
      acc = 0;
      for (int j = 0; j < idx; j++) acc += slots_for(int'(SIG_W[j]), DATA_W);
      return acc;
   endfunction

   localparam int USED_SLOTS = slots_before(N_SIG);
   localparam int SUM_W      = bits_before(N_SIG);

   // elaboration-time parameter checks
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("proj_wrapper: bus widths must be positive");
   end
   if (USED_SLOTS > (1 << ADDR_W)) begin : g_bad_space
      $error("proj_wrapper: signal table needs %0d slots, address space too small", USED_SLOTS);
   end
   if (SUM_W != TOTAL_W) begin : g_bad_total
      $error("proj_wrapper: TOTAL_W %0d differs from summed widths %0d", TOTAL_W, SUM_W);
   end

   logic [N_SIG-1:0]  hit;
   logic [ADDR_W-1:0] frag;
   slot_kind_e        kind;
   logic [DATA_W-1:0] q_arr [N_SIG];
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] dout_q;

   proj_addr_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .N_SIG     (N_SIG),
      .SIG_W     (SIG_W),
      .SIG_IS_IN (SIG_IS_IN)
   ) u_dec (
      .clk  (sys_clk),
      .rst  (rst),
      .addr (addr),
      .hit  (hit),
      .frag (frag),
      .kind (kind)
   );

   for (genvar i = 0; i < N_SIG; i++) begin : g_sig
      localparam int W   = int'(SIG_W[i]);
      localparam int OFF = bits_before(i);

      if (W < 1) begin : g_bad_width
         $error("proj_wrapper: signal %0d has zero width", i);
      end

      if (SIG_IS_IN[i]) begin : g_in
         logic [W-1:0] val;
         logic         unused_sense_bits;

         proj_in_reg #(.W(W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_reg (
            .clk   (sys_clk),
            .rst   (rst),
            .wr_en (we && hit[i]),
            .frag  (frag),
            .wdata (din),
            .val   (val)
         );

         proj_frag_sel #(.W(W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
            .val  (val),
            .frag (frag),
            .q    (q_arr[i])
         );

         assign drive_bus[OFF +: W] = val;
         assign unused_sense_bits   = ^sense_bus[OFF +: W];
      end else begin : g_out
         proj_frag_sel #(.W(W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
            .val  (sense_bus[OFF +: W]),
            .frag (frag),
            .q    (q_arr[i])
         );

         assign drive_bus[OFF +: W] = '0;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_SIG; i++) begin
         if (hit[i]) rd_data = rd_data | q_arr[i];
      end
   end

   // read-first: sampled from register contents before a same-edge write
   always_ff @(posedge sys_clk) begin
      if (rst) dout_q <= '0;
      else     dout_q <= rd_data;
   end

   assign dout   = dout_q;
   assign xp_clk = exp_clk;
   assign xp_rst = rst;

   AST_FREE_READS_ZERO: assert property (@(posedge sys_clk) disable iff (rst)
      (kind == SLOT_FREE) |=> (dout == '0)); // R8

   AST_RO_WRITE_IGNORED: assert property (@(posedge sys_clk) disable iff (rst)
      (we && kind != SLOT_RW) |=> $stable(drive_bus)); // R7

endmodule

// File: tb/tb_proj_wrapper.sv
module tb_proj_wrapper;

   logic        sys_clk = 1'b0;
   logic        exp_clk = 1'b0;
   logic        rst     = 1'b1;
   logic [2:0]  addr    = '0;
   logic        we      = 1'b0;
   logic [7:0]  din     = '0;
   logic [7:0]  dout;
   logic [25:0] drive_bus;
   logic [25:0] sense_bus;
   logic        xp_clk;
   logic        xp_rst;

   int nchk = 0;
   int nerr = 0;

   // bench-side expected state
   logic        e0 = 1'b0;
   logic        e1 = 1'b0;
   logic [11:0] e2 = '0;
   logic [11:0] mcnt = '0;

   // the example experiment: a 12-bit loadable counter
   logic [11:0] cnt = '0;

   always #10 sys_clk = ~sys_clk;

   proj_wrapper dut (
      .sys_clk   (sys_clk),
      .exp_clk   (exp_clk),
      .rst       (rst),
      .addr      (addr),
      .we        (we),
      .din       (din),
      .dout      (dout),
      .drive_bus (drive_bus),
      .sense_bus (sense_bus),
      .xp_clk    (xp_clk),
      .xp_rst    (xp_rst)
   );

   always @(posedge xp_clk) begin
      if (xp_rst)            cnt <= '0;
      else if (drive_bus[1]) cnt <= drive_bus[13:2];
      else if (drive_bus[0]) cnt <= cnt + 12'd1;
   end

   assign sense_bus = {cnt, 14'd0};

   function automatic logic [7:0] exp_read(input int a);
      case (a)
         0:       return {7'd0, e0};
         1:       return {7'd0, e1};
         2:       return {4'd0, e2[11:8]};
         3:       return e2[7:0];
         4:       return {4'd0, mcnt[11:8]};
         5:       return mcnt[7:0];
         default: return 8'd0;
      endcase
   endfunction

   function automatic logic [25:0] exp_bus();
      return {12'd0, e2, e1, e0};
   endfunction

   task automatic check(input logic [31:0] got, input logic [31:0] expv, input string tag);
      nchk++;
      if (got !== expv) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, got, expv);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge sys_clk);
      addr = 3'(a);
      we   = 1'b1;
      din  = d;
      @(negedge sys_clk);
      we   = 1'b0;
   endtask

   task automatic rd_chk(input int a, input string tag);
      @(negedge sys_clk);
      addr = 3'(a);
      we   = 1'b0;
      @(negedge sys_clk);
      check(32'(dout), 32'(exp_read(a)), tag);
   endtask

   task automatic pulse_xp();
      #3 exp_clk = 1'b1;
      #3 exp_clk = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge sys_clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [11:0] v;
      logic [7:0]  old;

      // R1 / R10: reset state
      repeat (3) @(posedge sys_clk);
      pulse_xp();
      @(negedge sys_clk);
      check(32'(dout), 0, "R1 dout at reset");
      check(32'(drive_bus), 0, "R1 drive_bus at reset");
      check(32'(xp_rst), 1, "R10 xp_rst follows rst");
      check(32'(cnt), 0, "R10 experiment reset through xp_rst");
      rst = 1'b0;
      #1 check(32'(xp_rst), 0, "R10 xp_rst released");

      // R2: sweep of the whole map after reset
      for (int a = 0; a < 8; a++) rd_chk(a, "R2 post-reset sweep");

      // R3 / R4 / R11: preload values through both slots, junk upper din bits
      for (int k = 0; k < 16; k++) begin
         v = 12'((k * 277 + 5) & 12'hFFF);
         wr(2, {4'(k) | 4'h8, v[11:8]});
         wr(3, v[7:0]);
         e2 = v;
         check(32'(drive_bus[13:2]), 32'(v), "R4 preload on drive_bus");
         rd_chk(2, "R3 high slot zero padded");
         rd_chk(3, "R11 low slot readback");
      end

      // R4: low slot only, high part untouched
      wr(3, 8'h3C);
      e2 = {e2[11:8], 8'h3C};
      check(32'(drive_bus), 32'(exp_bus()), "R4 single slot write");

      // R4 / R3: single-bit signals drop upper din bits
      wr(0, 8'hFE);
      e0 = 1'b0;
      check(32'(drive_bus), 32'(exp_bus()), "R4 truncated bit write");
      wr(0, 8'h01);
      e0 = 1'b1;
      rd_chk(0, "R3 single bit padded");
      rd_chk(1, "R11 load bit readback");

      // R9: counter experiment from two starting points, one wrapping
      for (int s = 0; s < 2; s++) begin
         v = (s == 0) ? 12'h0FF : 12'hFFE;
         wr(2, {4'd0, v[11:8]});
         wr(3, v[7:0]);
         e2 = v;
         wr(1, 8'h01);
         e1 = 1'b1;
         pulse_xp();
         mcnt = v;
         wr(1, 8'h00);
         e1 = 1'b0;
         rd_chk(4, "R9 loaded count high");
         rd_chk(5, "R9 loaded count low");
         for (int n = 0; n < 3; n++) begin
            pulse_xp();
            mcnt = mcnt + 12'd1;
            rd_chk(4, "R9 count high");
            rd_chk(5, "R9 count low");
         end
      end

      // R7 / R8: writes to read-only and unmapped slots
      for (int a = 4; a < 8; a++) begin
         wr(a, 8'hFF);
         check(32'(drive_bus), 32'(exp_bus()), "R7 ignored write");
      end
      rd_chk(4, "R7 output slot unchanged");
      rd_chk(5, "R7 output slot unchanged");
      rd_chk(6, "R8 unmapped read zero");
      rd_chk(7, "R8 unmapped read zero");

      // R6: collision returns the old value, then the new one
      old = e2[7:0];
      @(negedge sys_clk);
      addr = 3'd3;
      we   = 1'b1;
      din  = 8'h5A;
      @(negedge sys_clk);
      we = 1'b0;
      check(32'(dout), 32'(old), "R6 read-first on collision");
      e2 = {e2[11:8], 8'h5A};
      @(negedge sys_clk);
      check(32'(dout), 32'h5A, "R6 new value next read");

      // R5: back-to-back address changes, one edge of latency each
      @(negedge sys_clk);
      addr = 3'd2;
      @(negedge sys_clk);
      check(32'(dout), 32'(exp_read(2)), "R5 pipelined read a2");
      addr = 3'd5;
      @(negedge sys_clk);
      check(32'(dout), 32'(exp_read(5)), "R5 pipelined read a5");
      addr = 3'd0;
      @(negedge sys_clk);
      check(32'(dout), 32'(exp_read(0)), "R5 pipelined read a0");

      // R10: clock passthrough
      exp_clk = 1'b1;
      #1 check(32'(xp_clk), 1, "R10 xp_clk high");
      exp_clk = 1'b0;
      #1 check(32'(xp_clk), 0, "R10 xp_clk low");
      mcnt = mcnt + 12'd1;

      // R1: reset in mid-run
      @(negedge sys_clk);
      rst = 1'b1;
      @(negedge sys_clk);
      rst = 1'b0;
      e0 = 1'b0;
      e1 = 1'b0;
      e2 = '0;
      check(32'(drive_bus), 0, "R1 mid-run reset clears inputs");
      check(32'(dout), 0, "R1 mid-run reset clears dout");

      // R2: final sweep against the model
      for (int a = 0; a < 8; a++) rd_chk(a, "R2 final sweep");

      finish_run();
   end

endmodule